// File: doc/BRIEF.md
# Line Loss-of-Signal and Driver Activity Monitor

This block watches two serial streams and drives two alarm levels. The receive path samples a recovered line bit at each bit-clock enable. A long unbroken run of zeros on that path raises the loss-of-signal alarm. The second path watches a monitored transmit driver through two rail inputs, and a pulse on either rail counts as activity. If no activity appears for a fixed number of reference clock ticks, the driver-idle alarm rises.

The two alarms share a recovery rule. Once an alarm is set, its stream is judged in back-to-back, non-overlapping windows of 175 bit-clock samples. The alarm drops at the end of a window only if that window holds enough ones and has no overlong run of zeros. A window that fails the test is thrown away and the next one begins at once. Everything runs in one clock domain. The bit enable and the reference tick are single-cycle qualifiers in that domain.

Top module: `line_sig_monitor`

## Requirements
- R1: `los_o` rises on the clock edge that samples the 175th consecutive zero of `rx_bit`, counting only cycles with `bit_en` = 1. A run of 174 zeros leaves it low.
- R2: A sampled one on `rx_bit` restarts the zero run. Cycles with `bit_en` = 0 neither count toward the run nor break it.
- R3: `drv_idle_o` rises on the clock edge that samples the 512th `ref_tick` with no rail activity since the count last restarted. After 511 such ticks it is still low.
- R4: A high level on either `mon_pos` or `mon_neg` in any cycle restarts the inactivity count, whether or not `ref_tick` is high in that cycle.
- R5: While an alarm is high, its stream is sampled at each `bit_en` in windows of 175 samples. The first window starts with the first sample after the edge that set the alarm. If the window holds at least 22 ones and no zero run longer than 100, the alarm falls on the edge that takes the 175th sample.
- R6: A window with 21 or fewer ones leaves the alarm high, and a new window starts with the next sample.
- R7: A window that contains a run of 101 consecutive zeros leaves the alarm high even when its ones count is enough. A run of exactly 100 zeros does not block clearing.
- R8: The recovery test for `drv_idle_o` samples the ORed rails at each `bit_en`, and `rx_bit` has no effect on it.
- R9: A high `rst` on a clock edge clears both alarms and every counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-clock enable: the cycle carries one line bit |
| ref_tick | input | 1 | One reference clock period has elapsed |
| rx_bit | input | 1 | Recovered receive bit, 1 = pulse |
| mon_pos | input | 1 | Monitored driver, positive rail |
| mon_neg | input | 1 | Monitored driver, negative rail |
| los_o | output | 1 | Loss-of-signal alarm, registered |
| drv_idle_o | output | 1 | Driver-inactivity alarm, registered |

## Verification
Each alarm changes on the same edge that samples its deciding input: the 175th zero, the 512th idle tick, or the last sample of a recovery window. The bench drives inputs on the falling edge and reads outputs just after the next rising edge, so each check lands in the cycle the result is due. Boundary checks read the output one sample before the deciding one, where it must still hold its old level, and then right after it. The random segments compare both outputs against a bench model in every cycle.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int LOS_ZERO_RUN   = 175;
  localparam int IDLE_TICKS     = 512;
  localparam int WIN_BITS       = 175;
  localparam int WIN_MIN_ONES   = 22;
  localparam int WIN_MAX_ZRUN   = 100;
endpackage

// File: rtl/run_counter.sv
module run_counter #(
  parameter int LIMIT = 175
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic restart,
  input  logic inc,
  output logic hit
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt_q;

  assign hit = inc && !restart && !hold && (cnt_q == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || hold || restart || hit)
      cnt_q <= '0;
    else if (inc && cnt_q != W'(LIMIT))
      cnt_q <= cnt_q + 1'b1;
  end

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= W'(LIMIT - 1)); // R2

  AST_RUN_RESTART: assert property (@(posedge clk) disable iff (rst)
    restart |=> cnt_q == '0); // R2
endmodule

// File: rtl/density_window.sv
module density_window #(
  parameter int WIN_BITS = 175,
  parameter int MIN_ONES = 22,
  parameter int MAX_ZRUN = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic smp_en,
  input  logic smp_bit,
  output logic pass
);
  localparam int WW = $clog2(WIN_BITS + 1);
  localparam int OW = $clog2(MIN_ONES + 1);
  localparam int ZW = $clog2(MAX_ZRUN + 2);

  logic [WW-1:0] win_q;
  logic [OW-1:0] ones_q, ones_n;
  logic [ZW-1:0] zrun_q, zrun_n;
  logic          bad_q, bad_n, last;

  always_comb begin
    last   = (win_q == WW'(WIN_BITS - 1));
    ones_n = (smp_bit && ones_q != OW'(MIN_ONES)) ? ones_q + 1'b1 : ones_q;
    if (smp_bit)
      zrun_n = '0;
    else if (zrun_q == ZW'(MAX_ZRUN + 1))
      zrun_n = zrun_q;
    else
      zrun_n = zrun_q + 1'b1;
    bad_n  = bad_q || (zrun_n > ZW'(MAX_ZRUN));
    pass   = run && smp_en && last && (ones_n == OW'(MIN_ONES)) && !bad_n;
  end

  always_ff @(posedge clk) begin
    if (rst || !run || (smp_en && last)) begin
      win_q  <= '0;
      ones_q <= '0;
      zrun_q <= '0;
      bad_q  <= 1'b0;
    end else if (smp_en) begin
      win_q  <= win_q + 1'b1;
      ones_q <= ones_n;
      zrun_q <= zrun_n;
      bad_q  <= bad_n;
    end
  end

  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (rst)
    win_q < WW'(WIN_BITS)); // R5

  AST_ONES_SAT: assert property (@(posedge clk) disable iff (rst)
    ones_q <= OW'(MIN_ONES)); // R6

  AST_ZRUN_SAT: assert property (@(posedge clk) disable iff (rst)
    zrun_q <= ZW'(MAX_ZRUN + 1)); // R7
endmodule

// File: rtl/alarm_chan.sv
module alarm_chan #(
  parameter int SET_LIMIT = 175,
  parameter int WIN_BITS  = 175,
  parameter int MIN_ONES  = 22,
  parameter int MAX_ZRUN  = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic set_inc,
  input  logic set_restart,
  input  logic smp_en,
  input  logic smp_bit,
  output logic alarm
);
  logic alarm_q, hit, pass;

  run_counter #(.LIMIT(SET_LIMIT)) u_run (
    .clk(clk), .rst(rst), .hold(alarm_q), .restart(set_restart),
    .inc(set_inc), .hit(hit)
  );

  density_window #(.WIN_BITS(WIN_BITS), .MIN_ONES(MIN_ONES), .MAX_ZRUN(MAX_ZRUN)) u_win (
    .clk(clk), .rst(rst), .run(alarm_q), .smp_en(smp_en),
    .smp_bit(smp_bit), .pass(pass)
  );

  always_ff @(posedge clk) begin
    if (rst)
      alarm_q <= 1'b0;
    else if (hit)
      alarm_q <= 1'b1;
    else if (pass)
      alarm_q <= 1'b0;
  end

  assign alarm = alarm_q;

  AST_SET_NEEDS_INC: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_q) |-> $past(set_inc) && !$past(set_restart)); // R1

  AST_CLEAR_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    $fell(alarm_q) |-> $past(smp_en)); // R5
endmodule

// File: rtl/line_sig_monitor.sv
module line_sig_monitor
  import lsm_pkg::*;
#(
  parameter int LOS_RUN   = LOS_ZERO_RUN,
  parameter int IDLE_LIM  = IDLE_TICKS,
  parameter int WIN_LEN   = WIN_BITS,
  parameter int MIN_ONES  = WIN_MIN_ONES,
  parameter int MAX_ZRUN  = WIN_MAX_ZRUN
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic ref_tick,
  input  logic rx_bit,
  input  logic mon_pos,
  input  logic mon_neg,
  output logic los_o,
  output logic drv_idle_o
);
  logic mon_act;
  assign mon_act = mon_pos | mon_neg;

  alarm_chan #(.SET_LIMIT(LOS_RUN), .WIN_BITS(WIN_LEN),
               .MIN_ONES(MIN_ONES), .MAX_ZRUN(MAX_ZRUN)) u_los (
    .clk(clk), .rst(rst),
    .set_inc(bit_en & ~rx_bit), .set_restart(bit_en & rx_bit),
    .smp_en(bit_en), .smp_bit(rx_bit), .alarm(los_o)
  );

  alarm_chan #(.SET_LIMIT(IDLE_LIM), .WIN_BITS(WIN_LEN),
               .MIN_ONES(MIN_ONES), .MAX_ZRUN(MAX_ZRUN)) u_drv (
    .clk(clk), .rst(rst),
    .set_inc(ref_tick & ~mon_act), .set_restart(mon_act),
    .smp_en(bit_en), .smp_bit(mon_act), .alarm(drv_idle_o)
  );

  AST_LOS_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(los_o) |-> $past(bit_en) && !$past(rx_bit)); // R1

  AST_DRV_ON_IDLE_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_idle_o) |-> $past(ref_tick) && !$past(mon_pos) && !$past(mon_neg)); // R4

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !los_o && !drv_idle_o); // R9
endmodule

// File: tb/line_sig_monitor_tb.sv
`timescale 1ns/1ps
module line_sig_monitor_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0, ref_tick = 1'b0, rx_bit = 1'b1, mon_pos = 1'b0, mon_neg = 1'b0;
  logic los_o, drv_idle_o;
  int   n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  line_sig_monitor u_dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .ref_tick(ref_tick), .rx_bit(rx_bit),
    .mon_pos(mon_pos), .mon_neg(mon_neg), .los_o(los_o), .drv_idle_o(drv_idle_o)
  );

  // Bench model, written from the requirements: [0] loss of signal, [1] driver idle
  int m_run[2], m_win[2], m_ones[2], m_zr[2], m_long[2];
  bit m_al[2];

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_run[c] = 0; m_win[c] = 0; m_ones[c] = 0; m_zr[c] = 0; m_long[c] = 0; m_al[c] = 0;
    end
  endtask

  task automatic model_chan(int c, bit inc, bit rs, bit en, bit b);
    if (m_al[c]) begin
      m_run[c] = 0;
      if (en) begin
        m_win[c]++;
        m_ones[c] += b;
        m_zr[c] = b ? 0 : m_zr[c] + 1;
        if (m_zr[c] > m_long[c]) m_long[c] = m_zr[c];
        if (m_win[c] == 175) begin
          if (m_ones[c] >= 22 && m_long[c] <= 100) m_al[c] = 0;
          m_win[c] = 0; m_ones[c] = 0; m_zr[c] = 0; m_long[c] = 0;
        end
      end
    end else begin
      m_win[c] = 0; m_ones[c] = 0; m_zr[c] = 0; m_long[c] = 0;
      if (rs) m_run[c] = 0;
      else if (inc) begin
        m_run[c]++;
        if (m_run[c] == ((c == 0) ? 175 : 512)) begin m_al[c] = 1; m_run[c] = 0; end
      end
    end
  endtask

  task automatic step(bit be, bit rx, bit tk, bit mp, bit mn);
    @(negedge clk);
    bit_en = be; rx_bit = rx; ref_tick = tk; mon_pos = mp; mon_neg = mn;
    @(posedge clk);
    if (rst) model_reset();
    else begin
      model_chan(0, be & ~rx, be & rx, be, rx);
      model_chan(1, tk & ~(mp | mn), mp | mn, be, mp | mn);
    end
    #1;
  endtask

  task automatic check(string req, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(0, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    rst = 1'b0;
  endtask

  task automatic zeros(int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0);
  endtask

  // Feed a 175-sample recovery window to the loss path; kind 0: every 8th one (22),
  // 1: every 8th one below 168 (21), 2: 101 zeros then ones, 3: 100 zeros then ones.
  function automatic bit win_bit(int kind, int i);
    case (kind)
      0: return (i % 8 == 0);
      1: return (i % 8 == 0) && (i < 168);
      2: return i >= 101;
      default: return i >= 100;
    endcase
  endfunction

  task automatic los_window(int kind, string req, logic exp_end);
    for (int i = 0; i < 174; i++) step(1, win_bit(kind, i), 0, 0, 0);
    check(req, los_o, 1'b1);
    step(1, win_bit(kind, 174), 0, 0, 0);
    check(req, los_o, exp_end);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int seed_unused;
    seed_unused = $urandom(32'h5EED_0042);
    do_reset();
    check("R9 reset los", los_o, 1'b0);
    check("R9 reset drv", drv_idle_o, 1'b0);

    // R1 / R2 zero-run set boundary
    zeros(174);
    check("R1 174 zeros", los_o, 1'b0);
    step(0, 0, 0, 0, 0);
    check("R2 idle bit_en", los_o, 1'b0);
    step(1, 1, 0, 0, 0);
    zeros(174);
    check("R2 one restarts run", los_o, 1'b0);
    step(0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    check("R1 175th zero", los_o, 1'b1);

    los_window(0, "R5 clear 22 ones", 1'b0);
    zeros(175);
    check("R1 reassert", los_o, 1'b1);
    los_window(1, "R6 21 ones", 1'b1);
    los_window(0, "R6 next window clears", 1'b0);
    zeros(175);
    los_window(2, "R7 101-zero run", 1'b1);
    los_window(3, "R7 100-zero run", 1'b0);

    // R3 / R4 driver inactivity
    for (int i = 0; i < 500; i++) step(0, 1, 1, 0, 0);
    step(0, 1, 0, 0, 1);
    for (int i = 0; i < 511; i++) step(0, 1, 1, 0, 0);
    check("R4 neg rail restarts", drv_idle_o, 1'b0);
    step(0, 1, 1, 1, 0);
    for (int i = 0; i < 511; i++) step(0, 1, 1, 0, 0);
    check("R3 511 ticks", drv_idle_o, 1'b0);
    step(0, 1, 1, 0, 0);
    check("R3 512th tick", drv_idle_o, 1'b1);

    // R8 driver recovery with rx held low-density-free
    for (int i = 0; i < 174; i++) step(1, 0, 0, (i % 8 == 0), 0);
    check("R8 before window end", drv_idle_o, 1'b1);
    check("R8 los from rx zeros", los_o, 1'b0);
    step(1, 1, 0, 0, 0);
    check("R8 rails clear drv", drv_idle_o, 1'b0);

    // R9 reset while alarmed
    zeros(175);
    check("R9 los up", los_o, 1'b1);
    do_reset();
    check("R9 los cleared", los_o, 1'b0);
    model_reset();

    // Random segments against the model
    for (int s = 0; s < 40; s++) begin
      int  pz, pm;
      bit  bad;
      pz  = (s % 3 == 0) ? 0 : ((s % 3 == 1) ? 5 : 9);
      pm  = (s % 2 == 0) ? 0 : 4;
      bad = 0;
      for (int k = 0; k < 600; k++) begin
        bit be, rx, tk, mp, mn;
        be = ($urandom % 4) != 0;
        rx = (pz != 0) && (($urandom % pz) == 0);
        tk = ($urandom % 2) == 0;
        mp = (pm != 0) && (($urandom % pm) == 0);
        mn = (pm != 0) && (($urandom % (pm * 2)) == 0);
        step(be, rx, tk, mp, mn);
        if (!bad && (los_o !== m_al[0] || drv_idle_o !== m_al[1])) begin
          bad = 1;
          check("R5 random los", los_o, m_al[0]);
          check("R3 random drv", drv_idle_o, m_al[1]);
        end
      end
      if (!bad) n_run++;
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule